// File: doc/BRIEF.md
# Asynchronous Character Receiver with Sticky Error Flags

This block turns a serial receive line into parallel characters. It runs on a system clock and takes a one-cycle sampling tick that marks each oversampling period. A two-bit baud code picks how many ticks make up one bit: 1, 16 or 64. A further two-bit code picks the character length, and two more bits pick whether a parity bit is present and whether it is even or odd. The line passes through a synchronizer first. A falling edge seen on a tick then starts a frame.

In the 16x and 64x modes the start bit is checked again half a bit after the edge. A high level at that point discards the frame as noise. Each later bit is sampled once per bit period, so the sample lands at mid-bit. In 1x mode no centring is done: every tick samples one bit.

When the stop bit has been sampled, the character is stored right-aligned and the ready flag rises. Parity, framing and overrun conditions set flags that stay set until the host pulses the error-reset input. A host read pulse clears the ready flag. Reception only happens while the enable input is high and the baud code is not 00. The line settings are captured when a frame starts, so changing them later has no effect on a frame already in progress.

Top module: `async_char_rx`

## Requirements
- R1: Length code `char_len` 00, 01, 10 and 11 receives 5, 6, 7 and 8 data bits, least significant bit first. The character is placed right-aligned in `rx_data` and the unused upper bits read as zero.
- R2: When `parity_on` is 1, one parity bit follows the data. If the parity bit does not match the data, `parity_err` is set. A match means an even total count of ones across data and parity bit when `parity_even` is 1, and an odd total when it is 0.
- R3: If the stop bit is sampled low, `framing_err` is set. The character is still delivered.
- R4: If a character completes while `rx_ready` is still 1 and no `data_read` pulse comes in that cycle, `overrun_err` is set. The new character replaces the old one.
- R5: `parity_err`, `framing_err` and `overrun_err` keep their value until a one-cycle `err_reset` pulse, which clears all three on the next clock.
- R6: While `rx_enable` is 0 or `baud_mode` is 00, no character is received, and `rx_ready`, `rx_data` and the flags keep their values.
- R7: With `baud_mode` 10 (16 ticks per bit) or 11 (64 ticks per bit), the start bit is checked half a bit after the edge is detected. Each data, parity and stop bit is then sampled one full bit period after the previous sample.
- R8: A low pulse on `rxd` that has ended before the half-bit check, in 16x or 64x mode, is discarded. It produces no character, and a following valid frame is received correctly.
- R9: With `baud_mode` 01, the tick that detects the start edge counts as the start bit. Each following tick samples one bit.
- R10: A `data_read` pulse clears `rx_ready` on the next clock and leaves `rx_data` unchanged.
- R11: After reset, `rx_ready`, all three error flags and `rx_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_tick | input | 1 | One-cycle oversampling tick |
| rxd | input | 1 | Serial receive line, idle high |
| rx_enable | input | 1 | Receiver enable |
| baud_mode | input | 2 | 00 off, 01 1x, 10 16x, 11 64x |
| char_len | input | 2 | Data bits minus five |
| parity_on | input | 1 | Parity bit present |
| parity_even | input | 1 | 1 even parity, 0 odd parity |
| err_reset | input | 1 | Clears the three error flags |
| data_read | input | 1 | Host has taken the character |
| rx_data | output | DATA_W | Last received character, right-aligned |
| rx_ready | output | 1 | Unread character present |
| parity_err | output | 1 | Sticky parity error |
| framing_err | output | 1 | Sticky framing error |
| overrun_err | output | 1 | Sticky overrun error |

## Verification
A level change on `rxd` reaches the edge detector after SYNC_STAGES clocks, so it is first seen on the tick after the change. The stop-bit sample is registered on its tick edge, and `rx_ready`, `rx_data` and the flags follow one clock later. The bench therefore drives each bit right after a tick and keeps the line idle for two more ticks after the stop bit before it samples results on a falling clock edge. The effects of `data_read` and `err_reset` are due one clock after the pulse, and the bench samples them on the next falling edge.

// File: rtl/acr_pkg.sv
package acr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   typedef enum logic [1:0] {
      BF_OFF = 2'b00,
      BF_X1  = 2'b01,
      BF_X16 = 2'b10,
      BF_X64 = 2'b11
   } baud_code_e;

   typedef struct packed {
      logic [1:0]  len;
      logic        par_en;
      logic        par_even;
      baud_code_e  baud;
   } rx_cfg_t;

   localparam int MIN_CHAR_BITS = 5;

   function automatic int char_bits(input logic [1:0] code);
      return MIN_CHAR_BITS + int'(code);
   endfunction

endpackage

// File: rtl/acr_sync.sv
module acr_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

   initial begin
      assert (STAGES >= 2) else $error("acr_sync: STAGES must be at least 2");
   end

endmodule

// File: rtl/acr_bit_timer.sv
module acr_bit_timer
   import acr_pkg::*;
#(
   parameter int OVS_MID  = 16,
   parameter int OVS_HIGH = 64,
   parameter bit HIGH_EN  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       clear,
   input  logic       half,
   input  baud_code_e baud,
   output logic       sample
);

   localparam int TOP_TICKS = HIGH_EN ? OVS_HIGH : OVS_MID;
   localparam int CNT_W     = $clog2(TOP_TICKS);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   generate
      if (HIGH_EN) begin : g_two_rates
         always_comb begin
            case (baud)
               BF_X16:  lim = half ? CNT_W'(OVS_MID/2 - 1)  : CNT_W'(OVS_MID - 1);
               BF_X64:  lim = half ? CNT_W'(OVS_HIGH/2 - 1) : CNT_W'(OVS_HIGH - 1);
               default: lim = '0;
            endcase
         end
      end else begin : g_one_rate
         always_comb begin
            case (baud)
               BF_X16, BF_X64: lim = half ? CNT_W'(OVS_MID/2 - 1) : CNT_W'(OVS_MID - 1);
               default:        lim = '0;
            endcase
         end
      end
   endgenerate

   assign sample = tick && !clear && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clear)   cnt <= '0;
      else if (tick)    cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
   end

   // R7
   cnt_within_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |-> cnt <= lim);

   initial begin
      assert (OVS_MID >= 4 && OVS_MID % 2 == 0) else $error("acr_bit_timer: OVS_MID must be even and >= 4");
      assert (OVS_HIGH > OVS_MID && OVS_HIGH % 2 == 0) else $error("acr_bit_timer: OVS_HIGH must be even and above OVS_MID");
   end

endmodule

// File: rtl/acr_frame_fsm.sv
module acr_frame_fsm
   import acr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_en,
   input  logic              line_s,
   input  rx_cfg_t           cfg,
   input  logic              sample,
   output logic              tmr_clear,
   output logic              tmr_half,
   output baud_code_e        tmr_baud,
   output logic              done,
   output logic [DATA_W-1:0] char_out,
   output logic              par_bad,
   output logic              stop_bad
);

   localparam int IDX_W = $clog2(DATA_W + 1);

   rx_state_e         state;
   rx_cfg_t           cfg_l;
   logic [DATA_W-1:0] shreg;
   logic [IDX_W-1:0]  idx;
   logic              dxor;
   logic              par_bit;
   logic              line_prev;
   logic              active;
   logic              fall_seen;
   int                nb;

   assign active    = rx_en && (cfg.baud != BF_OFF);
   assign fall_seen = tick && line_prev && !line_s;
   assign nb        = char_bits(cfg_l.len);

   assign tmr_clear = (state == ST_IDLE);
   assign tmr_half  = (state == ST_START);
   assign tmr_baud  = cfg_l.baud;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cfg_l     <= '{len: 2'b00, par_en: 1'b0, par_even: 1'b0, baud: BF_OFF};
         shreg     <= '0;
         idx       <= '0;
         dxor      <= 1'b0;
         par_bit   <= 1'b0;
         line_prev <= 1'b1;
         done      <= 1'b0;
         char_out  <= '0;
         par_bad   <= 1'b0;
         stop_bad  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) line_prev <= line_s;
         if (!active) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_IDLE: begin
                  if (fall_seen) begin
                     cfg_l <= cfg;
                     idx   <= '0;
                     dxor  <= 1'b0;
                     shreg <= '0;
                     state <= (cfg.baud == BF_X1) ? ST_DATA : ST_START;
                  end
               end
               ST_START: begin
                  if (sample) state <= line_s ? ST_IDLE : ST_DATA;
               end
               ST_DATA: begin
                  if (sample) begin
                     shreg <= {line_s, shreg[DATA_W-1:1]};
                     dxor  <= dxor ^ line_s;
                     idx   <= idx + 1'b1;
                     if (idx == IDX_W'(nb - 1))
                        state <= cfg_l.par_en ? ST_PAR : ST_STOP;
                  end
               end
               ST_PAR: begin
                  if (sample) begin
                     par_bit <= line_s;
                     state   <= ST_STOP;
                  end
               end
               ST_STOP: begin
                  if (sample) begin
                     done     <= 1'b1;
                     char_out <= shreg >> (DATA_W - nb);
                     par_bad  <= cfg_l.par_en && ((dxor ^ par_bit) ^ ~cfg_l.par_even);
                     stop_bad <= !line_s;
                     state    <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R1
   upper_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((char_out >> nb) == '0));

   initial begin
      assert (DATA_W >= 8) else $error("acr_frame_fsm: DATA_W must hold an 8-bit character");
   end

endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
   import acr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS_MID     = 16,
   parameter int OVS_HIGH    = 64,
   parameter bit HIGH_EN     = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_tick,
   input  logic              rxd,
   input  logic              rx_enable,
   input  logic [1:0]        baud_mode,
   input  logic [1:0]        char_len,
   input  logic              parity_on,
   input  logic              parity_even,
   input  logic              err_reset,
   input  logic              data_read,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              parity_err,
   output logic              framing_err,
   output logic              overrun_err
);

   logic              line_s;
   logic              sample;
   logic              tmr_clear;
   logic              tmr_half;
   baud_code_e        tmr_baud;
   logic              frame_done;
   logic [DATA_W-1:0] frame_char;
   logic              frame_par_bad;
   logic              frame_stop_bad;
   rx_cfg_t           cfg;

   assign cfg = '{len: char_len, par_en: parity_on, par_even: parity_even,
                  baud: baud_code_e'(baud_mode)};

   acr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd),
      .q     (line_s)
   );

   acr_bit_timer #(.OVS_MID(OVS_MID), .OVS_HIGH(OVS_HIGH), .HIGH_EN(HIGH_EN)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (samp_tick),
      .clear  (tmr_clear),
      .half   (tmr_half),
      .baud   (tmr_baud),
      .sample (sample)
   );

   acr_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (samp_tick),
      .rx_en     (rx_enable),
      .line_s    (line_s),
      .cfg       (cfg),
      .sample    (sample),
      .tmr_clear (tmr_clear),
      .tmr_half  (tmr_half),
      .tmr_baud  (tmr_baud),
      .done      (frame_done),
      .char_out  (frame_char),
      .par_bad   (frame_par_bad),
      .stop_bad  (frame_stop_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data     <= '0;
         rx_ready    <= 1'b0;
         parity_err  <= 1'b0;
         framing_err <= 1'b0;
         overrun_err <= 1'b0;
      end else begin
         if (frame_done) rx_data <= frame_char;
         if (frame_done)     rx_ready <= 1'b1;
         else if (data_read) rx_ready <= 1'b0;
         parity_err  <= (parity_err  && !err_reset) || (frame_done && frame_par_bad);
         framing_err <= (framing_err && !err_reset) || (frame_done && frame_stop_bad);
         overrun_err <= (overrun_err && !err_reset) || (frame_done && rx_ready && !data_read);
      end
   end

   // R5
   flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(parity_err) || $fell(framing_err) || $fell(overrun_err)) |-> $past(err_reset));

   // R4
   overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_err) |-> $past(rx_ready));

   // R10
   read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_read && !frame_done) |=> !rx_ready);

   // R6
   disabled_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> !frame_done);

   initial begin
      assert (SYNC_STAGES >= 2) else $error("async_char_rx: SYNC_STAGES must be at least 2");
   end

endmodule

// File: tb/async_char_rx_tb.sv
module async_char_rx_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       samp_tick = 1'b0;
   logic       rxd = 1'b1;
   logic       rx_enable = 1'b0;
   logic [1:0] baud_mode = 2'b10;
   logic [1:0] char_len = 2'b11;
   logic       parity_on = 1'b0;
   logic       parity_even = 1'b0;
   logic       err_reset = 1'b0;
   logic       data_read = 1'b0;
   logic [7:0] rx_data;
   logic       rx_ready, parity_err, framing_err, overrun_err;

   int vecs = 0;
   int errs = 0;
   bit finished = 1'b0;

   logic [7:0] e_data = 8'h00;
   logic       e_ready = 1'b0, e_pe = 1'b0, e_fe = 1'b0, e_oe = 1'b0;

   async_char_rx u_dut (
      .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .rxd(rxd),
      .rx_enable(rx_enable), .baud_mode(baud_mode), .char_len(char_len),
      .parity_on(parity_on), .parity_even(parity_even), .err_reset(err_reset),
      .data_read(data_read), .rx_data(rx_data), .rx_ready(rx_ready),
      .parity_err(parity_err), .framing_err(framing_err), .overrun_err(overrun_err)
   );

   always #2 clk = ~clk;

   initial begin
      int tc = 0;
      forever begin
         @(negedge clk);
         tc = (tc + 1) % 4;
         samp_tick = (tc == 0);
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      int left = n;
      while (left > 0) begin
         @(posedge clk);
         if (samp_tick) left--;
      end
      @(negedge clk);
   endtask

   function automatic int ticks_per_bit(input logic [1:0] code);
      case (code)
         2'b01:   return 1;
         2'b10:   return 16;
         default: return 64;
      endcase
   endfunction

   function automatic logic [7:0] len_mask(input logic [1:0] code);
      return 8'hFF >> (3 - code);
   endfunction

   function automatic logic par_value(input logic [7:0] d, input logic even);
      return even ? ^d : ~(^d);
   endfunction

   task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic stop_val);
      int f = ticks_per_bit(baud_mode);
      int n = 5 + int'(char_len);
      logic [7:0] dm = d & len_mask(char_len);
      rxd = 1'b0;
      wait_ticks(f);
      for (int i = 0; i < n; i++) begin
         rxd = dm[i];
         wait_ticks(f);
      end
      if (parity_on) begin
         rxd = par_value(dm, parity_even) ^ bad_par;
         wait_ticks(f);
      end
      rxd = stop_val;
      wait_ticks(f);
      rxd = 1'b1;
      wait_ticks(2);
   endtask

   function automatic void model_frame(input logic [7:0] d, input logic bad_par, input logic stop_val);
      if (e_ready) e_oe = 1'b1;
      e_ready = 1'b1;
      e_data  = d & len_mask(char_len);
      if (parity_on && bad_par) e_pe = 1'b1;
      if (!stop_val) e_fe = 1'b1;
   endfunction

   task automatic check_all(input string tag);
      chk(tag, "rx_data", 32'(rx_data), 32'(e_data));
      chk(tag, "rx_ready", 32'(rx_ready), 32'(e_ready));
      chk("R2", "parity_err", 32'(parity_err), 32'(e_pe));
      chk("R3", "framing_err", 32'(framing_err), 32'(e_fe));
      chk("R4", "overrun_err", 32'(overrun_err), 32'(e_oe));
   endtask

   task automatic do_read();
      data_read = 1'b1;
      @(negedge clk);
      data_read = 1'b0;
      e_ready = 1'b0;
      chk("R10", "ready after read", 32'(rx_ready), 32'(0));
      chk("R10", "data after read", 32'(rx_data), 32'(e_data));
   endtask

   task automatic do_clear();
      err_reset = 1'b1;
      @(negedge clk);
      err_reset = 1'b0;
      e_pe = 1'b0; e_fe = 1'b0; e_oe = 1'b0;
      chk("R5", "flags after err_reset",
          32'({parity_err, framing_err, overrun_err}), 32'(0));
   endtask

   task automatic frame(input string tag, input logic [7:0] d, input logic bad_par, input logic stop_val);
      send_frame(d, bad_par, stop_val);
      model_frame(d, bad_par, stop_val);
      check_all(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errs++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11
      chk("R11", "reset state",
          32'({rx_data, rx_ready, parity_err, framing_err, overrun_err}), 32'(0));
      rx_enable = 1'b1;
      wait_ticks(3);

      // R1 every length, all ones, at 16x
      for (int l = 0; l < 4; l++) begin
         char_len = 2'(l);
         frame("R1", 8'hFF, 1'b0, 1'b1);
         do_read();
      end

      // R9 1x and R7 64x
      char_len = 2'b11; baud_mode = 2'b01;
      frame("R9", 8'hA5, 1'b0, 1'b1);
      do_read();
      baud_mode = 2'b11; char_len = 2'b10;
      frame("R7", 8'h4B, 1'b0, 1'b1);
      do_read();

      // R2 even and odd parity, good and bad
      baud_mode = 2'b10; char_len = 2'b11; parity_on = 1'b1;
      parity_even = 1'b1; frame("R2", 8'h37, 1'b0, 1'b1); do_read();
      parity_even = 1'b0; frame("R2", 8'h37, 1'b0, 1'b1); do_read();
      parity_even = 1'b1; frame("R2", 8'h81, 1'b1, 1'b1); do_read();
      // R5 flag persists across a clean frame
      frame("R5", 8'h12, 1'b0, 1'b1); do_read();
      do_clear();

      // R3 framing
      parity_on = 1'b0;
      frame("R3", 8'h5A, 1'b0, 1'b0); do_read();
      do_clear();

      // R4 overrun: two frames without a read
      frame("R4", 8'h11, 1'b0, 1'b1);
      frame("R4", 8'h22, 1'b0, 1'b1);
      do_read();
      do_clear();

      // R8 false start at 16x: low for 6 ticks
      rxd = 1'b0; wait_ticks(6); rxd = 1'b1; wait_ticks(40);
      chk("R8", "no char after glitch", 32'(rx_ready), 32'(0));
      frame("R8", 8'hC3, 1'b0, 1'b1); do_read();

      // R6 disabled, then baud code 00
      rx_enable = 1'b0;
      send_frame(8'h99, 1'b0, 1'b0);
      check_all("R6");
      rx_enable = 1'b1; baud_mode = 2'b00;
      send_frame(8'h66, 1'b0, 1'b0);
      check_all("R6");
      baud_mode = 2'b10;
      wait_ticks(2);

      // random frames
      for (int k = 0; k < 40; k++) begin
         int r = int'($urandom_range(0, 9));
         logic [7:0] d = 8'($urandom);
         logic bp = ($urandom_range(0, 99) < 15);
         logic sv = ($urandom_range(0, 99) >= 10);
         baud_mode   = (r < 3) ? 2'b01 : ((r < 8) ? 2'b10 : 2'b11);
         char_len    = 2'($urandom_range(0, 3));
         parity_on   = 1'($urandom);
         parity_even = 1'($urandom);
         frame((baud_mode == 2'b01) ? "R9" : "R7", d, bp, sv);
         if ($urandom_range(0, 99) < 60) do_read();
         if ($urandom_range(0, 99) < 25) do_clear();
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule